// File: doc/BRIEF.md
# Background Flash Stream Reader

This block moves a linear run of 32-bit words out of a flash interface and into a small FIFO while the main execute-in-place path carries on. Software programs a word-aligned start address and then a word count. A nonzero count starts the stream, and the engine keeps working with no further software action. It issues one read per word, and only in cycles when the foreground path leaves the flash interface idle. Each returned word is placed in a streaming FIFO. A DMA empties that FIFO through a dedicated auxiliary port, so the DMA never waits behind cached traffic.

The flash side is a plain request/valid handshake. Responses come back in request order after a latency that can vary. Writing zero to the count aborts a stream. Reads already in flight are then marked for discard: their responses are swallowed as they arrive and never reach the FIFO. A new stream may therefore be programmed in the very next cycle. The engine never has more reads outstanding than the FIFO has free, unreserved entries, so the FIFO cannot overflow.

Top module: `stream_rd_engine`

## Requirements
- R1: After a synchronous reset, the address, count and status registers read zero, no flash read is requested, and the FIFO is empty (aux_level = 0).
- R2: The register map is selected by reg_sel:
  - 0 is the start/current address. Bits 1:0 always read zero.
  - 1 is the count. It holds 22 bits in 21:0. Bits 31:22 ignore writes and read zero.
  - 2 is status. Bit 0 is the sticky underflow flag. Bit 1 is busy, meaning the count is nonzero or a live read is outstanding. All other status bits read zero.
- R3: fl_req is never high in a cycle where fg_busy is high.
- R4: Reads go to consecutive word addresses, starting at the programmed address. Each issued read advances the address register by 4, modulo 2^ADDR_W. After a stream of N words, the address register therefore reads start + 4N.
- R5: A nonzero count write starts a stream. The count drops by exactly one for each read issued. No read is issued while the count is zero, so a finished stream reads count 0.
- R6: Writing zero to the count (ignoring bits 31:22) halts the stream at once. Data from every read in flight at that moment is discarded and never enters the FIFO.
- R7: A new address and a nonzero count may be written immediately after an abort. The first word the FIFO then delivers belongs to the new start address.
- R8: Words leave the FIFO in order. aux_rdata shows the oldest word, aux_rd removes it, and aux_level gives the number of stored words.
- R9: An aux_rd while the FIFO is empty returns aux_rdata = 0 and sets status bit 0. The flag stays set until software writes status with bit 0 = 1.
- R10: A read is issued only if the FIFO level plus the live reads in flight is below FIFO_DEPTH. The total of live and discarded outstanding reads never exceeds MAX_INFLIGHT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 address, 1 count, 2 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_sel (combinational) |
| fg_busy | input | 1 | Foreground path owns the flash interface this cycle |
| fl_req | output | 1 | Flash read request, one word |
| fl_addr | output | ADDR_W | Byte address of the requested word |
| fl_valid | input | 1 | Flash response valid (in request order) |
| fl_rdata | input | 32 | Flash response data |
| aux_rd | input | 1 | Auxiliary port pop strobe |
| aux_rdata | output | 32 | Oldest FIFO word, zero when empty |
| aux_level | output | LVL_W | Number of words held in the FIFO |

## Verification
The bench builds the block with FIFO_DEPTH = 4 and MAX_INFLIGHT = 2. With these values, a ten-word stream that nobody drains stops on the credit limit within a few cycles. An abort during a twelve-cycle flash latency then leaves discarded reads outstanding, and those block the slot limit while a new stream starts. Foreground-busy patterns of several duty cycles, an address run that wraps past 2^24, and an unaligned start address are run from a vector table. Directed tests then cover the reserved count bits, abort with discard, immediate restart, and the sticky underflow flag.

// File: rtl/stream_pkg.sv
package stream_pkg;

    typedef enum logic [1:0] {
        SEL_ADDR   = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_STATUS = 2'd2,
        SEL_NONE   = 2'd3
    } reg_sel_e;

    localparam int WORD_BYTES = 4;
    localparam int STAT_UNDERFLOW = 0;
    localparam int STAT_BUSY      = 1;

    typedef struct packed {
        logic        we;
        reg_sel_e    sel;
        logic [31:0] wdata;
    } reg_cmd_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] data;
    } flash_rsp_t;

    function automatic logic [31:0] status_word(input logic underflow, input logic busy);
        logic [31:0] w;
        w = '0;
        w[STAT_UNDERFLOW] = underflow;
        w[STAT_BUSY]      = busy;
        return w;
    endfunction

endpackage

// File: rtl/stream_fifo.sv
module stream_fifo #(
    parameter int W = 32,
    parameter int DEPTH = 8,
    localparam int PW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [LW-1:0] level,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wp, rp;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (level == '0);
        full    = (level == LW'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        head    = empty ? '0 : mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/stream_ctl.sv
module stream_ctl
    import stream_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  reg_cmd_t          cmd,
    input  logic              issue,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              hold,
    output logic              abort
);
    logic addr_wr, cnt_wr;

    always_comb begin
        addr_wr = cmd.we && (cmd.sel == SEL_ADDR);
        cnt_wr  = cmd.we && (cmd.sel == SEL_COUNT);
        hold    = addr_wr || cnt_wr;
        abort   = cnt_wr && (cmd.wdata[CNT_W-1:0] == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (addr_wr)
                addr_q <= {cmd.wdata[ADDR_W-1:2], 2'b00};
            else if (issue)
                addr_q <= addr_q + ADDR_W'(WORD_BYTES);

            if (cnt_wr)
                cnt_q <= cmd.wdata[CNT_W-1:0];
            else if (issue)
                cnt_q <= cnt_q - 1'b1;
        end
    end
endmodule

// File: rtl/stream_track.sv
module stream_track #(
    parameter int DEPTH = 8,
    parameter int MAX_INFLIGHT = 4,
    localparam int LW = $clog2(DEPTH + 1),
    localparam int IW = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          want,
    input  logic          fg_busy,
    input  logic [LW-1:0] fifo_level,
    input  logic          abort,
    input  logic          fl_valid,
    output logic          issue,
    output logic          push,
    output logic [IW-1:0] live_q,
    output logic [IW-1:0] drop_q
);
    logic credit_ok, slot_ok, rsp_any, rsp_drop, rsp_keep;

    always_comb begin
        credit_ok = (int'(fifo_level) + int'(live_q)) < DEPTH;
        slot_ok   = (int'(live_q) + int'(drop_q)) < MAX_INFLIGHT;
        issue     = want && !fg_busy && credit_ok && slot_ok && !abort;
        rsp_any   = fl_valid && ((live_q != '0) || (drop_q != '0));
        rsp_drop  = rsp_any && (drop_q != '0);
        rsp_keep  = rsp_any && (drop_q == '0);
        push      = rsp_keep && !abort;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live_q <= '0;
            drop_q <= '0;
        end else if (abort) begin
            live_q <= '0;
            drop_q <= drop_q + live_q - IW'(rsp_any);
        end else begin
            live_q <= live_q + IW'(issue) - IW'(rsp_keep);
            drop_q <= drop_q - IW'(rsp_drop);
        end
    end
endmodule

// File: rtl/stream_rd_engine.sv
module stream_rd_engine
    import stream_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int CNT_W = 22,
    parameter int FIFO_DEPTH = 8,
    parameter int MAX_INFLIGHT = 4,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1),
    localparam int IF_W = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fg_busy,
    output logic              fl_req,
    output logic [ADDR_W-1:0] fl_addr,
    input  logic              fl_valid,
    input  logic [31:0]       fl_rdata,
    input  logic              aux_rd,
    output logic [31:0]       aux_rdata,
    output logic [LVL_W-1:0]  aux_level
);
    reg_cmd_t          cmd;
    flash_rsp_t        rsp;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              hold, abort, issue, push, want;
    logic [IF_W-1:0]   live_q, drop_q;
    logic              fifo_empty, fifo_full;
    logic [31:0]       fifo_head;
    logic              underflow_q, uf_clear;

    always_comb begin
        cmd.we    = reg_we;
        cmd.sel   = reg_sel_e'(reg_sel);
        cmd.wdata = reg_wdata;
        rsp.valid = fl_valid;
        rsp.data  = fl_rdata;
        want      = (cnt_q != '0) && !hold;
    end

    stream_ctl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctl (
        .clk(clk), .rst(rst), .cmd(cmd), .issue(issue),
        .addr_q(addr_q), .cnt_q(cnt_q), .hold(hold), .abort(abort)
    );

    stream_track #(.DEPTH(FIFO_DEPTH), .MAX_INFLIGHT(MAX_INFLIGHT)) u_track (
        .clk(clk), .rst(rst), .want(want), .fg_busy(fg_busy),
        .fifo_level(aux_level), .abort(abort), .fl_valid(rsp.valid),
        .issue(issue), .push(push), .live_q(live_q), .drop_q(drop_q)
    );

    stream_fifo #(.W(32), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push(push), .push_data(rsp.data),
        .pop(aux_rd), .head(fifo_head), .level(aux_level),
        .empty(fifo_empty), .full(fifo_full)
    );

    always_comb begin
        fl_req    = issue;
        fl_addr   = addr_q;
        aux_rdata = fifo_head;
        uf_clear  = cmd.we && (cmd.sel == SEL_STATUS) && cmd.wdata[STAT_UNDERFLOW];
    end

    always_ff @(posedge clk) begin
        if (rst)
            underflow_q <= 1'b0;
        else if (aux_rd && fifo_empty)
            underflow_q <= 1'b1;
        else if (uf_clear)
            underflow_q <= 1'b0;
    end

    always_comb begin
        case (cmd.sel)
            SEL_ADDR:   reg_rdata = 32'(addr_q);
            SEL_COUNT:  reg_rdata = 32'(cnt_q);
            SEL_STATUS: reg_rdata = status_word(underflow_q, (cnt_q != '0) || (live_q != '0));
            default:    reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/stream_rd_chk.sv
module stream_rd_chk #(
    parameter int DEPTH = 8,
    parameter int MAXF = 4,
    parameter int AW = 24,
    parameter int CW = 22,
    parameter int LW = 4,
    parameter int IW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          fl_req,
    input logic          fg_busy,
    input logic [AW-1:0] addr_q,
    input logic [CW-1:0] cnt_q,
    input logic          abort,
    input logic          push,
    input logic          fifo_full,
    input logic          fifo_empty,
    input logic [LW-1:0] level,
    input logic [IW-1:0] live_q,
    input logic [IW-1:0] drop_q,
    input logic          aux_rd,
    input logic [31:0]   aux_rdata
);
    AST_IDLE_SLOT: assert property (@(posedge clk) disable iff (rst)
        fl_req |-> !fg_busy);                                           // R3
    AST_STOP_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '0) |-> !fl_req);                                     // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
        fl_req |=> (cnt_q == CW'($past(cnt_q) - 1'b1)));                // R5
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
        fl_req |=> (addr_q == AW'($past(addr_q) + 3'd4)));              // R4
    AST_ABORT_NO_PUSH: assert property (@(posedge clk) disable iff (rst)
        abort |-> !push);                                               // R6
    AST_ABORT_CLEARS_LIVE: assert property (@(posedge clk) disable iff (rst)
        abort |=> (live_q == '0));                                      // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        push |-> !fifo_full);                                           // R10
    AST_CREDIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (int'(level) + int'(live_q)) <= DEPTH);                         // R10
    AST_SLOT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (int'(live_q) + int'(drop_q)) <= MAXF);                         // R10
    AST_EMPTY_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (aux_rd && fifo_empty) |-> (aux_rdata == '0));                  // R9
endmodule

bind stream_rd_engine stream_rd_chk #(
    .DEPTH(FIFO_DEPTH), .MAXF(MAX_INFLIGHT), .AW(ADDR_W), .CW(CNT_W),
    .LW(LVL_W), .IW(IF_W)
) u_chk (
    .clk(clk), .rst(rst), .fl_req(fl_req), .fg_busy(fg_busy),
    .addr_q(addr_q), .cnt_q(cnt_q), .abort(abort), .push(push),
    .fifo_full(fifo_full), .fifo_empty(fifo_empty), .level(aux_level),
    .live_q(live_q), .drop_q(drop_q), .aux_rd(aux_rd), .aux_rdata(aux_rdata)
);

// File: tb/stream_rd_engine_tb.sv
module stream_rd_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 24;
    localparam int DEPTH = 4;
    localparam int MAXF = 2;
    localparam int LW = $clog2(DEPTH + 1);
    localparam int WD_LIMIT = 150000;

    typedef struct packed {
        logic [23:0] addr;
        logic [15:0] cnt;
        logic [1:0]  fg;
        logic [3:0]  lat;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VEC [NVEC] = '{
        '{24'h000100, 16'd6, 2'd0, 4'd1},
        '{24'h001000, 16'd9, 2'd1, 4'd3},
        '{24'h00FFF0, 16'd5, 2'd3, 4'd5},
        '{24'hFFFFF8, 16'd4, 2'd0, 4'd2},
        '{24'h000203, 16'd3, 2'd1, 4'd4}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_sel = 2'd0;
    logic [31:0]   reg_wdata = '0;
    logic [31:0]   reg_rdata;
    logic          fg_busy = 1'b0;
    logic          fl_req;
    logic [AW-1:0] fl_addr;
    logic          fl_valid = 1'b0;
    logic [31:0]   fl_rdata = '0;
    logic          aux_rd = 1'b0;
    logic [31:0]   aux_rdata;
    logic [LW-1:0] aux_level;

    int n_chk = 0, n_bad = 0, cyc = 0, last_due = 0, busy_issue = 0;
    int fg_mode = 0, lat = 1;
    bit done = 0;
    logic [AW-1:0] pq_addr [$];
    int            pq_due  [$];

    stream_rd_engine #(.ADDR_W(AW), .CNT_W(22), .FIFO_DEPTH(DEPTH), .MAX_INFLIGHT(MAXF)) u_dut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .fg_busy(fg_busy), .fl_req(fl_req), .fl_addr(fl_addr),
        .fl_valid(fl_valid), .fl_rdata(fl_rdata), .aux_rd(aux_rd), .aux_rdata(aux_rdata),
        .aux_level(aux_level)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] fdata(input logic [AW-1:0] a);
        return {a, 8'h00} ^ 32'(a) ^ 32'hC3000000;
    endfunction

    // flash model: in-order responses with programmable latency, plus foreground load
    always @(posedge clk) begin
        int due;
        cyc = cyc + 1;
        if (rst) begin
            pq_addr.delete();
            pq_due.delete();
            fl_valid <= 1'b0;
            fg_busy  <= 1'b0;
        end else begin
            if (fl_req) begin
                if (fg_busy) busy_issue = busy_issue + 1;
                due = cyc + lat;
                if (due <= last_due) due = last_due + 1;
                last_due = due;
                pq_addr.push_back(fl_addr);
                pq_due.push_back(due);
            end
            if (pq_due.size() > 0 && pq_due[0] <= cyc) begin
                fl_valid <= 1'b1;
                fl_rdata <= fdata(pq_addr.pop_front());
                void'(pq_due.pop_front());
            end else begin
                fl_valid <= 1'b0;
            end
            case (fg_mode)
                0: fg_busy <= 1'b0;
                1: fg_busy <= cyc[0];
                2: fg_busy <= 1'b1;
                default: fg_busy <= (cyc % 3) != 0;
            endcase
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc >= WD_LIMIT && !done) begin
            done = 1;
            n_chk = n_chk + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: act=%0d cycles exp=<%0d", cyc, WD_LIMIT);
            summary();
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic pop(output logic [31:0] d);
        @(negedge clk);
        #1 d = aux_rdata;
        aux_rd = 1'b1;
        @(negedge clk);
        aux_rd = 1'b0;
    endtask

    task automatic wait_word();
        for (int t = 0; t < 500; t++) begin
            @(negedge clk);
            if (aux_level != '0) break;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        logic [31:0] d;
        logic [AW-1:0] base;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(2'd0, d); check("R1 addr", d, 32'h0);
        rd(2'd1, d); check("R1 count", d, 32'h0);
        rd(2'd2, d); check("R1 status", d, 32'h0);
        check("R1 level", 32'(aux_level), 32'h0);
        check("R1 fl_req", 32'(fl_req), 32'h0);

        // R2 reserved count bits; foreground always busy keeps count frozen (R3)
        fg_mode = 2; idle(2);
        wr(2'd1, 32'hFFFF_FFFF);
        rd(2'd1, d); check("R2 count reserved bits", d, 32'h003F_FFFF);
        rd(2'd2, d); check("R2 status busy", d, 32'h2);
        idle(10);
        rd(2'd1, d); check("R3 no issue while fg busy", d, 32'h003F_FFFF);
        wr(2'd1, 32'h0);
        rd(2'd1, d); check("R5 count after abort", d, 32'h0);

        // vector table: streams under several foreground patterns and latencies
        for (int v = 0; v < NVEC; v++) begin
            fg_mode = int'(VEC[v].fg);
            lat     = int'(VEC[v].lat);
            base    = {VEC[v].addr[23:2], 2'b00};
            wr(2'd0, 32'(VEC[v].addr));
            wr(2'd1, 32'(VEC[v].cnt));
            for (int i = 0; i < int'(VEC[v].cnt); i++) begin
                wait_word();
                pop(d);
                check($sformatf("R8 R4 vec%0d word%0d", v, i), d, fdata(base + AW'(4 * i)));
            end
            idle(4);
            rd(2'd1, d); check($sformatf("R5 vec%0d count end", v), d, 32'h0);
            rd(2'd0, d); check($sformatf("R4 vec%0d addr end", v), d,
                               32'(AW'(base + AW'(4 * int'(VEC[v].cnt)))));
            rd(2'd2, d); check($sformatf("R2 vec%0d status idle", v), d, 32'h0);
        end
        check("R3 issues during fg busy", 32'(busy_issue), 32'h0);

        // R10 credit: no draining, stream stops at FIFO depth
        fg_mode = 0; lat = 1;
        wr(2'd0, 32'h400);
        wr(2'd1, 32'd10);
        idle(40);
        check("R10 level at depth", 32'(aux_level), 32'(DEPTH));
        rd(2'd1, d); check("R10 count held", d, 32'(10 - DEPTH));
        rd(2'd0, d); check("R10 addr held", d, 32'h400 + 32'(4 * DEPTH));
        for (int i = 0; i < 10; i++) begin
            wait_word();
            pop(d);
            check($sformatf("R8 credit word%0d", i), d, fdata(AW'(32'h400 + 32'(4 * i))));
        end
        idle(4);
        check("R8 level drained", 32'(aux_level), 32'h0);

        // R6 abort with reads in flight
        lat = 12;
        wr(2'd0, 32'h800);
        wr(2'd1, 32'd50);
        idle(3);
        wr(2'd1, 32'h0);
        idle(30);
        check("R6 nothing enters fifo", 32'(aux_level), 32'h0);
        rd(2'd1, d); check("R6 count zero", d, 32'h0);
        rd(2'd2, d); check("R6 status idle", d, 32'h0);

        // R7 restart immediately after an abort
        wr(2'd0, 32'hC00);
        wr(2'd1, 32'd40);
        idle(3);
        wr(2'd1, 32'h0);
        wr(2'd0, 32'hA00);
        wr(2'd1, 32'd2);
        wait_word();
        pop(d); check("R7 first word new stream", d, fdata(24'hA00));
        wait_word();
        pop(d); check("R7 second word new stream", d, fdata(24'hA04));
        idle(40);
        check("R7 no stale words", 32'(aux_level), 32'h0);

        // R9 underflow
        pop(d); check("R9 empty read data", d, 32'h0);
        rd(2'd2, d); check("R9 underflow set", d, 32'h1);
        idle(5);
        rd(2'd2, d); check("R9 underflow sticky", d, 32'h1);
        wr(2'd2, 32'h1);
        rd(2'd2, d); check("R9 underflow cleared", d, 32'h0);

        done = 1;
        summary();
    end
endmodule